// File: doc/BRIEF.md
# MII Receive MAC with Pause Detection

This block sits on the receive side of an Ethernet MAC behind a 4-bit media-independent receive interface. It looks for the start-of-frame delimiter in the nibble stream and throws away every preamble nibble. It then pairs nibbles into bytes, low nibble first, and hands every frame byte after the delimiter, the frame check sequence included, to the host. The host sees a valid strobe with start and end markers. When the frame closes, the end beat carries three error flags: a bad CRC-32, a code violation reported by the PHY, and a frame shorter than the minimum size.

The block also watches for MAC control frames, which are sent to the reserved control multicast address with the control EtherType. A configuration input decides whether these frames reach the host or are removed from the host stream completely. A fixed-depth byte delay line makes this decision possible without a frame buffer: no byte leaves the block until the header has been seen. A control frame that carries the PAUSE opcode, is error-free and is at least minimum size produces a single-cycle pause request toward the local transmitter. The request carries the 16-bit quanta value from the frame, counted in units of 512 bit times.

Frames are expected to be separated by a normal inter-frame gap of at least 24 nibble times. The delay line drains at one byte per cycle after the valid signal falls, and it must finish before the next frame delivers its first byte.

Top module: `eth_mii_rx_mac`

## Requirements
- R1: While `mii_dv` is high, a nibble 0x5 immediately followed by a nibble 0xD marks the delimiter. Nothing before it is forwarded, and a 0xD preceded by any other nibble is treated as preamble. The first byte after the delimiter is delivered with `host_sof` high.
- R2: Each pair of data nibbles forms one byte, with the first nibble in bits 3:0 and the second in bits 7:4. Every byte after the delimiter, including the four FCS bytes, is delivered once and in order.
- R3: Each delivered frame has exactly one `host_sof` beat and then exactly one `host_eof` beat, which is its last byte. The three error flags are only ever high on a valid end beat.
- R4: The CRC-32 check starts from all ones and runs over every byte after the delimiter. If the check register does not end at the good residue, `host_err_crc` is set on the end beat. The good residue is 0xC704DD7B in most-significant-bit-first form.
- R5: If `mii_err` is high while `mii_dv` is high in the data part of a frame, `host_err_code` is set on that frame's end beat.
- R6: A frame of fewer than 64 bytes from the first byte after the delimiter through the last FCS byte sets `host_err_runt` on its end beat. A frame of exactly 64 bytes does not.
- R7: A frame is a control frame when bytes 0..5 are 01 80 C2 00 00 01 and bytes 12..13 are 88 08. With `cfg_pass_ctrl` low, a control frame produces no host beats at all. With it high, the frame is forwarded like any other. Other frames are forwarded whatever their EtherType.
- R8: A control frame whose bytes 14..15 are 00 01 (PAUSE) and that is error-free produces a one-cycle `pause_valid` after it ends. At the same time `pause_quanta` shows bytes 16..17, with byte 16 as the upper half.
- R9: A PAUSE frame with an FCS mismatch, a code violation or a runt length produces no `pause_valid`.
- R10: A control frame with any opcode other than 00 01 produces no `pause_valid`. It still follows the forward-or-drop policy of R7.
- R11: If `mii_dv` falls before a delimiter is seen, nothing is delivered and no pause request is raised.
- R12: While reset is held and right after it, `host_valid`, all markers and flags, and `pause_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_dv | input | 1 | Receive data valid from the PHY |
| mii_d | input | 4 | Receive nibble |
| mii_err | input | 1 | Receive code violation from the PHY |
| cfg_pass_ctrl | input | 1 | 1 forwards control frames to the host, 0 drops them; keep stable during a frame |
| host_valid | output | 1 | A byte is present on host_data |
| host_data | output | 8 | Received byte |
| host_sof | output | 1 | First byte of a frame |
| host_eof | output | 1 | Last byte of a frame |
| host_err_crc | output | 1 | FCS mismatch, on the end beat |
| host_err_code | output | 1 | Code violation seen in the frame, on the end beat |
| host_err_runt | output | 1 | Frame shorter than 64 bytes, on the end beat |
| pause_valid | output | 1 | One-cycle pause request toward the transmitter |
| pause_quanta | output | 16 | Pause time in 512-bit-time units, meaningful with pause_valid |

## Verification
Every cycle, the assertions check the framing rules of the host stream. A start beat may not open a second frame, and a middle beat may not appear outside one. Error flags must come only with a valid end beat. They also check that a pause request is a single pulse raised at the end of a frame whose CRC check passed and which had no code violation, and that a code-error flag is backed by a violation the nibble stage latched. Whether the bytes are right, whether the correct frames are dropped and whether the quanta value is right can only be shown by the bench's scenarios. The bench compares each delivered beat with a behavioural model of the frames it sent: noisy and minimal preambles, corrupted FCS, code errors, lengths just below and at 64 bytes, and control frames of every kind under both policies.

// File: rtl/eth_mii_rx_pkg.sv
package eth_mii_rx_pkg;
   localparam logic [3:0]  PRE_NIB   = 4'h5;
   localparam logic [3:0]  SFD_NIB   = 4'hD;
   localparam logic [31:0] POLY_REFL = 32'hEDB88320;

   typedef enum logic {ST_SEEK, ST_DATA} rx_state_t;

   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c ^ {24'd0, b};
      for (int i = 0; i < 8; i++)
         r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
      return r;
   endfunction

   function automatic logic [31:0] bitrev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++)
         r[i] = v[31 - i];
      return r;
   endfunction
endpackage

// File: rtl/mrx_nibble_rx.sv
module mrx_nibble_rx
   import eth_mii_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dv,
   input  logic [3:0] d,
   input  logic       er,
   output logic       byte_stb,
   output logic [7:0] byte_dat,
   output logic       frm_start,
   output logic       frm_end,
   output logic       code_err
);
   rx_state_t  st;
   logic       saw_pre;
   logic       half;
   logic [3:0] lo_nib;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_SEEK;
         saw_pre   <= 1'b0;
         half      <= 1'b0;
         lo_nib    <= '0;
         byte_stb  <= 1'b0;
         byte_dat  <= '0;
         frm_start <= 1'b0;
         frm_end   <= 1'b0;
         code_err  <= 1'b0;
      end else begin
         byte_stb  <= 1'b0;
         frm_start <= 1'b0;
         frm_end   <= 1'b0;
         case (st)
            ST_SEEK: begin
               if (dv) begin
                  if (saw_pre && d == SFD_NIB) begin
                     st        <= ST_DATA;
                     frm_start <= 1'b1;
                     code_err  <= 1'b0;
                     half      <= 1'b0;
                     saw_pre   <= 1'b0;
                  end else begin
                     saw_pre <= (d == PRE_NIB);
                  end
               end else begin
                  saw_pre <= 1'b0;
               end
            end
            default: begin
               if (dv) begin
                  code_err <= code_err | er;
                  if (!half) begin
                     lo_nib <= d;
                     half   <= 1'b1;
                  end else begin
                     byte_stb <= 1'b1;
                     byte_dat <= {d, lo_nib};
                     half     <= 1'b0;
                  end
               end else begin
                  st      <= ST_SEEK;
                  frm_end <= 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/mrx_crc_chk.sv
module mrx_crc_chk
   import eth_mii_rx_pkg::*;
#(
   parameter logic [31:0] RESIDUE = 32'hC704DD7B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       stb,
   input  logic [7:0] dat,
   output logic       crc_ok
);
   localparam logic [31:0] RES_REFL = bitrev32(RESIDUE);

   logic [31:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '1;
      else if (start) crc_q <= '1;
      else if (stb)   crc_q <= crc32_step(crc_q, dat);
   end

   assign crc_ok = (crc_q == RES_REFL);
endmodule

// File: rtl/mrx_ctrl_parse.sv
module mrx_ctrl_parse #(
   parameter int          CNT_W     = 16,
   parameter int          MIN_FRAME = 64,
   parameter logic [47:0] CTRL_DA   = 48'h0180C2000001,
   parameter logic [15:0] CTRL_TYPE = 16'h8808,
   parameter logic [15:0] PAUSE_OP  = 16'h0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        stb,
   input  logic [7:0]  dat,
   input  logic        frm_end,
   input  logic        crc_ok,
   input  logic        code_err,
   output logic        ctrl_hdr,
   output logic        runt,
   output logic        pause_valid,
   output logic [15:0] pause_quanta
);
   localparam logic [CNT_W-1:0] HDR_END = CNT_W'(14);
   localparam logic [CNT_W-1:0] Q_END   = CNT_W'(18);

   logic [CNT_W-1:0] cnt;
   logic             hdr_ok, op_ok, hdr_hit, op_hit;
   logic [47:0]      da_sh;

   always_comb begin
      da_sh   = CTRL_DA >> (8 * (5 - cnt[2:0]));
      hdr_hit = 1'b1;
      op_hit  = 1'b1;
      if (cnt < CNT_W'(6))         hdr_hit = (dat == da_sh[7:0]);
      else if (cnt == CNT_W'(12))  hdr_hit = (dat == CTRL_TYPE[15:8]);
      else if (cnt == CNT_W'(13))  hdr_hit = (dat == CTRL_TYPE[7:0]);
      else if (cnt == CNT_W'(14))  op_hit  = (dat == PAUSE_OP[15:8]);
      else if (cnt == CNT_W'(15))  op_hit  = (dat == PAUSE_OP[7:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt          <= '0;
         hdr_ok       <= 1'b0;
         op_ok        <= 1'b0;
         pause_quanta <= '0;
         pause_valid  <= 1'b0;
      end else begin
         pause_valid <= frm_end & hdr_ok & op_ok & (cnt >= Q_END) &
                        crc_ok & ~code_err & ~runt;
         if (start) begin
            cnt    <= '0;
            hdr_ok <= 1'b1;
            op_ok  <= 1'b1;
         end else if (stb) begin
            if (cnt != '1) cnt <= cnt + CNT_W'(1);
            hdr_ok <= hdr_ok & hdr_hit;
            op_ok  <= op_ok & op_hit;
            if (cnt == CNT_W'(16)) pause_quanta[15:8] <= dat;
            if (cnt == CNT_W'(17)) pause_quanta[7:0]  <= dat;
         end
      end
   end

   assign ctrl_hdr = hdr_ok & (cnt >= HDR_END);
   assign runt     = (cnt < CNT_W'(MIN_FRAME));
endmodule

// File: rtl/mrx_hold_line.sv
module mrx_hold_line #(
   parameter int HOLD = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       stb,
   input  logic [7:0] dat,
   input  logic       frm_end,
   input  logic       drop,
   input  logic       crc_ok,
   input  logic       code_err,
   input  logic       runt,
   output logic       host_valid,
   output logic [7:0] host_data,
   output logic       host_sof,
   output logic       host_eof,
   output logic       host_err_crc,
   output logic       host_err_code,
   output logic       host_err_runt
);
   localparam int PW = $clog2(HOLD + 1) + 1;

   logic          draining, first_q;
   logic [PW-1:0] pend;
   logic          fl_crc, fl_code, fl_runt;
   logic          shift, emit, is_last, pass;

   assign shift = stb | draining;

   for (genvar g = 0; g < HOLD; g++) begin : g_stage
      logic [7:0] d_q;
      logic       v_q;
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
            end else if (shift) begin
               d_q <= dat;
               v_q <= stb;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
            end else if (shift) begin
               d_q <= g_stage[g-1].d_q;
               v_q <= g_stage[g-1].v_q;
            end
         end
      end
   end

   assign emit    = shift & g_stage[HOLD-1].v_q;
   assign is_last = draining & (pend == PW'(1));
   assign pass    = emit & ~drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         draining      <= 1'b0;
         first_q       <= 1'b0;
         pend          <= '0;
         fl_crc        <= 1'b0;
         fl_code       <= 1'b0;
         fl_runt       <= 1'b0;
         host_valid    <= 1'b0;
         host_data     <= '0;
         host_sof      <= 1'b0;
         host_eof      <= 1'b0;
         host_err_crc  <= 1'b0;
         host_err_code <= 1'b0;
         host_err_runt <= 1'b0;
      end else begin
         host_valid    <= pass;
         host_data     <= pass ? g_stage[HOLD-1].d_q : 8'h00;
         host_sof      <= pass & first_q;
         host_eof      <= pass & is_last;
         host_err_crc  <= pass & is_last & fl_crc;
         host_err_code <= pass & is_last & fl_code;
         host_err_runt <= pass & is_last & fl_runt;
         pend <= pend + {{(PW-1){1'b0}}, stb} - {{(PW-1){1'b0}}, emit};
         if (start)     first_q <= 1'b1;
         else if (emit) first_q <= 1'b0;
         if (frm_end) begin
            fl_crc  <= ~crc_ok;
            fl_code <= code_err;
            fl_runt <= runt;
            if (pend != '0) draining <= 1'b1;
         end else if (emit && is_last) begin
            draining <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/eth_mii_rx_mac.sv
module eth_mii_rx_mac #(
   parameter int          HOLD_BYTES = 14,
   parameter int          CNT_W      = 16,
   parameter int          MIN_FRAME  = 64,
   parameter logic [31:0] CRC_RESIDUE = 32'hC704DD7B,
   parameter logic [47:0] CTRL_DA    = 48'h0180C2000001,
   parameter logic [15:0] CTRL_TYPE  = 16'h8808,
   parameter logic [15:0] PAUSE_OP   = 16'h0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mii_dv,
   input  logic [3:0]  mii_d,
   input  logic        mii_err,
   input  logic        cfg_pass_ctrl,
   output logic        host_valid,
   output logic [7:0]  host_data,
   output logic        host_sof,
   output logic        host_eof,
   output logic        host_err_crc,
   output logic        host_err_code,
   output logic        host_err_runt,
   output logic        pause_valid,
   output logic [15:0] pause_quanta
);
   if (HOLD_BYTES < 14) begin : g_bad_hold
      $error("HOLD_BYTES must cover the 14-byte header");
   end
   if (MIN_FRAME < 18 || (64'(1) << CNT_W) <= 64'(MIN_FRAME)) begin : g_bad_len
      $error("MIN_FRAME out of range for CNT_W");
   end

   logic       byte_stb, frm_start, frm_end, code_err, crc_ok;
   logic       ctrl_hdr, runt;
   logic [7:0] byte_dat;

   mrx_nibble_rx u_nib (
      .clk(clk), .rst_n(rst_n), .dv(mii_dv), .d(mii_d), .er(mii_err),
      .byte_stb(byte_stb), .byte_dat(byte_dat), .frm_start(frm_start),
      .frm_end(frm_end), .code_err(code_err)
   );

   mrx_crc_chk #(.RESIDUE(CRC_RESIDUE)) u_crc (
      .clk(clk), .rst_n(rst_n), .start(frm_start), .stb(byte_stb),
      .dat(byte_dat), .crc_ok(crc_ok)
   );

   mrx_ctrl_parse #(
      .CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME), .CTRL_DA(CTRL_DA),
      .CTRL_TYPE(CTRL_TYPE), .PAUSE_OP(PAUSE_OP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(frm_start), .stb(byte_stb),
      .dat(byte_dat), .frm_end(frm_end), .crc_ok(crc_ok), .code_err(code_err),
      .ctrl_hdr(ctrl_hdr), .runt(runt), .pause_valid(pause_valid),
      .pause_quanta(pause_quanta)
   );

   mrx_hold_line #(.HOLD(HOLD_BYTES)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(frm_start), .stb(byte_stb),
      .dat(byte_dat), .frm_end(frm_end), .drop(ctrl_hdr & ~cfg_pass_ctrl),
      .crc_ok(crc_ok), .code_err(code_err), .runt(runt),
      .host_valid(host_valid), .host_data(host_data), .host_sof(host_sof),
      .host_eof(host_eof), .host_err_crc(host_err_crc),
      .host_err_code(host_err_code), .host_err_runt(host_err_runt)
   );
endmodule

// File: rtl/eth_mii_rx_mac_chk.sv
module eth_mii_rx_mac_chk (
   input logic clk,
   input logic rst_n,
   input logic host_valid,
   input logic host_sof,
   input logic host_eof,
   input logic host_err_crc,
   input logic host_err_code,
   input logic host_err_runt,
   input logic pause_valid,
   input logic crc_ok,
   input logic code_err,
   input logic frm_end
);
   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q <= 1'b0;
      else if (host_valid && host_eof) open_q <= 1'b0;
      else if (host_valid && host_sof) open_q <= 1'b1;
   end

   assert_err_on_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_err_crc || host_err_code || host_err_runt) |-> (host_valid && host_eof));

   assert_marker_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sof || host_eof) |-> host_valid);

   assert_sof_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && host_sof) |-> !open_q);

   assert_mid_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_sof) |-> open_q);

   assert_pause_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pause_valid |=> !pause_valid);

   assert_pause_good_fcs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pause_valid |-> ($past(frm_end) && $past(crc_ok) && !$past(code_err)));

   assert_code_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_err_code |-> code_err);
endmodule

bind eth_mii_rx_mac eth_mii_rx_mac_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_sof(host_sof),
   .host_eof(host_eof), .host_err_crc(host_err_crc),
   .host_err_code(host_err_code), .host_err_runt(host_err_runt),
   .pause_valid(pause_valid), .crc_ok(crc_ok), .code_err(code_err),
   .frm_end(frm_end)
);

// File: tb/eth_mii_rx_mac_tb.sv
`timescale 1ns/1ps
module eth_mii_rx_mac_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mii_dv = 1'b0, mii_err = 1'b0, cfg_pass_ctrl = 1'b0;
   logic [3:0]  mii_d = '0;
   logic        host_valid, host_sof, host_eof;
   logic        host_err_crc, host_err_code, host_err_runt, pause_valid;
   logic [7:0]  host_data;
   logic [15:0] pause_quanta;

   always #2.5 clk = ~clk;

   eth_mii_rx_mac u_dut (
      .clk(clk), .rst_n(rst_n), .mii_dv(mii_dv), .mii_d(mii_d), .mii_err(mii_err),
      .cfg_pass_ctrl(cfg_pass_ctrl), .host_valid(host_valid), .host_data(host_data),
      .host_sof(host_sof), .host_eof(host_eof), .host_err_crc(host_err_crc),
      .host_err_code(host_err_code), .host_err_runt(host_err_runt),
      .pause_valid(pause_valid), .pause_quanta(pause_quanta)
   );

   typedef struct packed {
      logic [7:0] d;
      logic sof, eof, ecrc, ecode, erunt;
   } beat_t;

   localparam logic [47:0] CDA = 48'h0180C2000001;

   beat_t       exp_q[$];
   logic [15:0] pq[$];
   logic [7:0]  fr[$];
   logic [3:0]  pre[$];
   beat_t       e;
   logic [15:0] eq;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   function automatic logic [31:0] crc_over(input int n);
      logic [31:0] c;
      c = '1;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'd0, fr[i]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic mk_frame(input int n_data, input logic [47:0] da,
                           input logic [15:0] typ, input logic [15:0] op,
                           input logic [15:0] q, input bit bad_fcs);
      logic [31:0] f;
      fr.delete();
      for (int i = 5; i >= 0; i--) fr.push_back(da[8*i +: 8]);
      for (int i = 0; i < 6; i++) fr.push_back(8'h20 + 8'(i));
      fr.push_back(typ[15:8]); fr.push_back(typ[7:0]);
      fr.push_back(op[15:8]);  fr.push_back(op[7:0]);
      fr.push_back(q[15:8]);   fr.push_back(q[7:0]);
      while (fr.size() > n_data) void'(fr.pop_back());
      while (fr.size() < n_data) fr.push_back(8'(fr.size() * 7 + 3));
      f = crc_over(n_data);
      for (int i = 0; i < 4; i++) fr.push_back(f[8*i +: 8]);
      if (bad_fcs) fr[fr.size()-1] = fr[fr.size()-1] ^ 8'h10;
   endtask

   task automatic std_pre();
      pre.delete();
      for (int i = 0; i < 15; i++) pre.push_back(4'h5);
      pre.push_back(4'hD);
   endtask

   task automatic model(input int err_idx);
      int n;
      bit ctrl, good, runt, code;
      logic [31:0] f;
      beat_t b;
      n = fr.size();
      ctrl = (n >= 14) && fr[12] == 8'h88 && fr[13] == 8'h08;
      for (int i = 0; i < 6 && i < n; i++) if (fr[i] != CDA[8*(5-i) +: 8]) ctrl = 0;
      good = 0;
      if (n >= 4) begin
         f = crc_over(n - 4);
         good = (f == {fr[n-1], fr[n-2], fr[n-3], fr[n-4]});
      end
      runt = (n < 64);
      code = (err_idx >= 0) && (err_idx < n);
      if (!(ctrl && !cfg_pass_ctrl))
         for (int i = 0; i < n; i++) begin
            b.d = fr[i]; b.sof = (i == 0); b.eof = (i == n-1);
            b.ecrc = b.eof && !good; b.ecode = b.eof && code; b.erunt = b.eof && runt;
            exp_q.push_back(b);
         end
      if (ctrl && n >= 18 && fr[14] == 8'h00 && fr[15] == 8'h01 && good && !code && !runt)
         pq.push_back({fr[16], fr[17]});
   endtask

   task automatic nib(input logic [3:0] v, input bit er);
      @(negedge clk);
      mii_dv = 1'b1; mii_d = v; mii_err = er;
   endtask

   task automatic run(input int err_idx, input string tag);
      model(err_idx);
      foreach (pre[i]) nib(pre[i], 1'b0);
      foreach (fr[i]) begin
         nib(fr[i][3:0], i == err_idx);
         nib(fr[i][7:4], 1'b0);
      end
      @(negedge clk);
      mii_dv = 1'b0; mii_d = '0; mii_err = 1'b0;
      repeat (40) @(negedge clk);
      chk(exp_q.size() == 0, tag, "beats still expected", exp_q.size(), 0);
      chk(pq.size() == 0, tag, "pause requests missing", pq.size(), 0);
      exp_q.delete(); pq.delete();
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (host_valid) begin
            if (exp_q.size() == 0) chk(0, "R7", "unexpected host byte", host_data, 0);
            else begin
               e = exp_q.pop_front();
               chk(host_data == e.d, "R2", "data", host_data, e.d);
               chk(host_sof == e.sof, "R1", "sof", host_sof, e.sof);
               chk(host_eof == e.eof, "R3", "eof", host_eof, e.eof);
               chk(host_err_crc == e.ecrc, "R4", "crc flag", host_err_crc, e.ecrc);
               chk(host_err_code == e.ecode, "R5", "code flag", host_err_code, e.ecode);
               chk(host_err_runt == e.erunt, "R6", "runt flag", host_err_runt, e.erunt);
            end
         end
         if (pause_valid) begin
            if (pq.size() == 0) chk(0, "R9", "unexpected pause", pause_quanta, 0);
            else begin
               eq = pq.pop_front();
               chk(pause_quanta == eq, "R8", "quanta", pause_quanta, eq);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL R2 watchdog expired: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!host_valid && !host_sof && !host_eof && !pause_valid, "R12", "outputs in reset",
          {host_valid, host_sof, host_eof, pause_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!host_valid && !host_err_crc && !host_err_code && !host_err_runt && !pause_valid,
          "R12", "outputs after reset", {host_valid, host_err_crc, pause_valid}, 0);

      // R1 R2 R6 boundary: 64-byte good frame
      std_pre(); mk_frame(60, 48'h0A0B0C0D0E0F, 16'h0800, 16'h4500, 16'h1234, 0); run(-1, "R2");
      // R1: noisy preamble with a D not preceded by 5
      pre = '{4'h5, 4'hA, 4'hD, 4'h5, 4'h3, 4'h5, 4'h5, 4'hD};
      mk_frame(80, 48'h112233445566, 16'h86DD, 16'h0000, 16'h0000, 0); run(-1, "R1");
      // R4: corrupted FCS
      std_pre(); mk_frame(60, 48'h0A0B0C0D0E0F, 16'h0800, 16'h0, 16'h0, 1); run(-1, "R4");
      // R5: code violation mid frame
      mk_frame(60, 48'h0A0B0C0D0E0F, 16'h0800, 16'h0, 16'h0, 0); run(20, "R5");
      // R6: runt and 63-byte boundary
      mk_frame(16, 48'h0A0B0C0D0E0F, 16'h0800, 16'h0, 16'h0, 0); run(-1, "R6");
      mk_frame(59, 48'h0A0B0C0D0E0F, 16'h0800, 16'h0, 16'h0, 0); run(-1, "R6");
      // R1 R6: minimal preamble, 8-byte frame
      pre = '{4'h5, 4'hD};
      mk_frame(4, 48'hA1A2A3A4A5A6, 16'h0, 16'h0, 16'h0, 0); run(-1, "R6");
      // R7 R8: pause dropped and forwarded
      std_pre(); cfg_pass_ctrl = 1'b0;
      mk_frame(60, CDA, 16'h8808, 16'h0001, 16'h1234, 0); run(-1, "R7");
      cfg_pass_ctrl = 1'b1;
      mk_frame(60, CDA, 16'h8808, 16'h0001, 16'hFFFF, 0); run(-1, "R8");
      // R9: errored pause frames
      mk_frame(60, CDA, 16'h8808, 16'h0001, 16'h0100, 1); run(-1, "R9");
      cfg_pass_ctrl = 1'b0;
      mk_frame(60, CDA, 16'h8808, 16'h0001, 16'h0200, 0); run(30, "R9");
      mk_frame(18, CDA, 16'h8808, 16'h0001, 16'h0300, 0); run(-1, "R9");
      // R10: other control opcode
      mk_frame(60, CDA, 16'h8808, 16'h0002, 16'h0400, 0); run(-1, "R10");
      // R7: control EtherType to another address is ordinary
      mk_frame(60, 48'h0180C2000002, 16'h8808, 16'h0001, 16'h0500, 0); run(-1, "R7");
      // R11: preamble aborted before the delimiter
      pre = '{4'h5, 4'h5, 4'h5, 4'h5, 4'h5};
      fr.delete(); run(-1, "R11");
      // R2: normal traffic again after all of the above
      std_pre(); cfg_pass_ctrl = 1'b1;
      mk_frame(100, 48'h0A0B0C0D0E0F, 16'h0800, 16'h0, 16'h0, 0); run(-1, "R2");

      done = 1;
      summary();
      $finish;
   end
endmodule